// File: doc/BRIEF.md
# Bit-Serial Reflected CRC-8 Accumulator

This block keeps a running 8-bit cyclic redundancy check over a stream of bytes, in the right-shifting, reflected form used to protect identity codes and data blocks on single-wire sensor buses. A byte is offered with a one-cycle valid strobe. The block then folds it into the register one bit per clock, least significant bit first, and shows a busy flag for the eight cycles this takes.

The register carries its value from one byte to the next, so a caller feeds a message byte by byte and reads the result once busy drops. A clear strobe returns the register to zero before a new message. When a message is followed by its own check byte, the register returns to zero. The zero flag then reports a good message directly. Framing of messages and the choice of bytes to check belong to the caller.

Top module: `crc8r_accum`

## Requirements
- R1: After reset the CRC output is 0x00, the zero flag is high and busy is low.
- R2: Each bit step computes feedback = crc[0] XOR data bit, shifts the register right by one with a 0 entering bit 7, and XORs the shifted value with 0x8C when feedback is 1. Data bits are taken bit 0 first, eight per byte.
- R3: Every byte update starts from the register value that the previous byte left, so the output after several bytes equals the reference model applied to those bytes in sequence.
- R4: A clear strobe sets the register to 0x00 and drops busy on the next clock. This holds when the block is idle, when a byte is in flight (that byte is abandoned), and when a byte strobe arrives in the same cycle (that byte is dropped).
- R5: The zero flag is high exactly when the CRC output equals 0x00.
- R6: An accepted byte strobe raises busy on the next clock. Busy stays high for exactly eight clocks, and the final CRC is on the output in the first cycle that busy is low again.
- R7: A byte strobe that arrives while busy is high is ignored. It neither changes the result of the byte in flight nor lengthens busy.
- R8: For an 8-byte identity code whose last byte is the CRC of the first seven, the register ends at 0x00 with the zero flag high.
- R9: While busy is low and no clear occurs, the CRC output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear strobe: register to 0x00, abort any byte in flight |
| byte_vld_i | input | 1 | Byte strobe: take byte_i when idle |
| byte_i | input | 8 | Data byte, consumed bit 0 first |
| crc_o | output | 8 | Running CRC register |
| zero_o | output | 1 | High when crc_o is 0x00 |
| busy_o | output | 1 | High while a byte is being folded in |

## Verification
The scoreboard compares each byte result against a bitwise model. The patterns are chosen so that a wrong feedback tap, an MSB-first bit order or a missing carry between bytes each gives a different value. A strobe injected mid-byte would, in a design that restarts, change the result and stretch busy past eight cycles, and a design that queues it would give a second busy period; both are caught. Clear is driven while idle, in the middle of a byte and together with a byte strobe. A design that lets the byte win or finish would leave a nonzero register or busy still high. A full identity code with its check byte must end at zero, which exposes any off-by-one in the number of bits per byte.

// File: rtl/crc8r_pkg.sv
package crc8r_pkg;

   // Controller states of the bit-serial engine
   typedef enum logic {
      CRC_IDLE = 1'b0,
      CRC_RUN  = 1'b1
   } crc8r_state_e;

   // Default geometry of the accumulator
   localparam int          CRC_W_DEF  = 8;
   localparam int          DATA_W_DEF = 8;
   localparam logic [7:0]  POLY_DEF   = 8'h8C;

endpackage

// File: rtl/crc8r_step.sv
// One bit of the reflected CRC: shift right, XOR the constant on feedback.
module crc8r_step #(
   parameter int               CRC_W = 8,
   parameter logic [CRC_W-1:0] POLY  = 8'h8C
) (
   input  logic [CRC_W-1:0] crc_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc_o
);

   logic             fb;
   logic [CRC_W-1:0] shifted;

   assign fb      = crc_i[0] ^ bit_i;
   assign shifted = {1'b0, crc_i[CRC_W-1:1]};

   for (genvar i = 0; i < CRC_W; i++) begin : g_tap
      if (POLY[i]) begin : g_xor
         assign crc_o[i] = shifted[i] ^ fb;
      end else begin : g_pass
         assign crc_o[i] = shifted[i];
      end
   end

endmodule

// File: rtl/crc8r_shreg.sv
// Data holding register: loads a byte, presents bit 0, shifts right.
module crc8r_shreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              bit_o
);

   logic [DATA_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= data_i;
      end else if (shift_i) begin
         sr_q <= sr_q >> 1;
      end
   end

   assign bit_o = sr_q[0];

endmodule

// File: rtl/crc8r_seq.sv
// Sequencer: accepts a strobe when idle, then runs DATA_W step cycles.
module crc8r_seq
   import crc8r_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o
);

   localparam int              CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   crc8r_state_e     state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CRC_IDLE;
         cnt_q   <= '0;
      end else if (clr_i) begin
         state_q <= CRC_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            CRC_IDLE: begin
               cnt_q <= '0;
               if (start_i) state_q <= CRC_RUN;
            end
            CRC_RUN: begin
               if (cnt_q == LAST) begin
                  cnt_q   <= '0;
                  state_q <= CRC_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               state_q <= CRC_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign busy_o = (state_q == CRC_RUN);
   assign step_o = busy_o && !clr_i;
   assign load_o = start_i && !busy_o && !clr_i;

endmodule

// File: rtl/crc8r_accum.sv
// Reflected CRC accumulator, one data bit per clock.
module crc8r_accum #(
   parameter int               CRC_W  = crc8r_pkg::CRC_W_DEF,
   parameter int               DATA_W = crc8r_pkg::DATA_W_DEF,
   parameter logic [CRC_W-1:0] POLY   = crc8r_pkg::POLY_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              zero_o,
   output logic              busy_o
);

   initial begin : p_param_chk
      if (CRC_W < 2)   $error("crc8r_accum: CRC_W must be at least 2");
      if (DATA_W < 1)  $error("crc8r_accum: DATA_W must be at least 1");
      if (POLY == '0)  $error("crc8r_accum: POLY must be nonzero");
   end

   logic             load;
   logic             step;
   logic             dbit;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   crc8r_seq #(.DATA_W(DATA_W)) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_i),
      .start_i (byte_vld_i),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o)
   );

   crc8r_shreg #(.DATA_W(DATA_W)) shreg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .shift_i (step),
      .data_i  (byte_i),
      .bit_o   (dbit)
   );

   crc8r_step #(.CRC_W(CRC_W), .POLY(POLY)) step_i (
      .crc_i (crc_q),
      .bit_i (dbit),
      .crc_o (crc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
      end else if (clr_i) begin
         crc_q <= '0;
      end else if (step) begin
         crc_q <= crc_nxt;
      end
   end

   assign crc_o  = crc_q;
   assign zero_o = (crc_q == '0);

endmodule

// File: rtl/crc8r_accum_chk.sv
module crc8r_accum_chk #(
   parameter int               CRC_W  = 8,
   parameter int               DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY   = 8'h8C
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_i,
   input logic             byte_vld_i,
   input logic             busy_o,
   input logic [CRC_W-1:0] crc_o
);

   localparam int RC_W = $clog2(DATA_W + 2);

   logic [RC_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_cnt <= '0;
      else if (busy_o) run_cnt <= run_cnt + 1'b1;
      else             run_cnt <= '0;
   end

   AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !busy_o && !clr_i) |=> busy_o); // R6

   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && !$past(clr_i)) |-> (int'(run_cnt) == DATA_W)); // R6

   AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(run_cnt) <= DATA_W)); // R7

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (crc_o == '0 && !busy_o)); // R4

   AST_STEP_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !clr_i) |=> ((crc_o == ($past(crc_o) >> 1)) ||
                              (crc_o == (($past(crc_o) >> 1) ^ POLY)))); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !clr_i) |=> $stable(crc_o)); // R9

endmodule

bind crc8r_accum crc8r_accum_chk #(
   .CRC_W (CRC_W),
   .DATA_W(DATA_W),
   .POLY  (POLY)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_i      (clr_i),
   .byte_vld_i (byte_vld_i),
   .busy_o     (busy_o),
   .crc_o      (crc_o)
);

// File: tb/crc8r_accum_tb_top.sv
module crc8r_accum_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_i = 1'b0;
   logic       byte_vld_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic [7:0] crc_o;
   logic       zero_o;
   logic       busy_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit abort_run = 1'b0;
   logic [7:0] m_crc = '0;
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   crc8r_accum dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_i),
      .byte_vld_i (byte_vld_i),
      .byte_i     (byte_i),
      .crc_o      (crc_o),
      .zero_o     (zero_o),
      .busy_o     (busy_o)
   );

   function automatic logic [7:0] ref_byte(logic [7:0] c, logic [7:0] d);
      logic [7:0] r = c;
      logic [7:0] x = d;
      for (int i = 0; i < 8; i++) begin
         logic fb = r[0] ^ x[0];
         r = r >> 1;
         if (fb) r = r ^ 8'h8C;
         x = x >> 1;
      end
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Driver: pushes the expected result and pulses the strobe.
   // extra=1 injects a second strobe while busy (must be ignored).
   task automatic send_byte(logic [7:0] b, bit extra);
      @(negedge clk);
      byte_i     = b;
      byte_vld_i = 1'b1;
      m_crc      = ref_byte(m_crc, b);
      exp_q.push_back(m_crc);
      @(negedge clk);
      byte_vld_i = 1'b0;
      if (extra) begin
         repeat (2) @(negedge clk);
         byte_i     = ~b;
         byte_vld_i = 1'b1;
         @(negedge clk);
         byte_vld_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: measures busy length and compares each finished byte.
   initial begin : p_mon
      int blen = 0;
      forever begin
         @(negedge clk);
         if (busy_o) begin
            blen++;
         end else if (blen > 0) begin
            if (!abort_run) begin
               logic [7:0] e;
               chk("R6 busy length", blen, 8);
               if (exp_q.size() == 0) begin
                  chk("R7 unexpected extra byte", 1, 0);
               end else begin
                  e = exp_q.pop_front();
                  chk("R2/R3 crc", crc_o, e);
                  chk("R5 zero flag", zero_o, (e == 8'h00));
               end
            end
            blen = 0;
         end
      end
   end

   initial begin : p_wdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk("watchdog", 0, 1);
         report();
      end
   end

   initial begin : p_main
      logic [7:0] rom[8];
      logic [7:0] held;
      repeat (4) @(negedge clk);
      chk("R1 crc after reset", crc_o, 8'h00);
      chk("R1 busy after reset", busy_o, 1'b0);
      chk("R5 zero after reset", zero_o, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);

      // Several distinct patterns, chained (R2, R3)
      send_byte(8'h00, 1'b0);
      send_byte(8'h01, 1'b0);
      send_byte(8'h80, 1'b0);
      send_byte(8'hFF, 1'b0);
      send_byte(8'hA5, 1'b0);
      send_byte(8'h3C, 1'b0);

      // Hold while idle (R9)
      held = crc_o;
      repeat (6) @(negedge clk);
      chk("R9 idle hold", crc_o, held);

      // Strobe during busy ignored (R7)
      send_byte(8'h5A, 1'b1);
      send_byte(8'hC3, 1'b1);
      chk("R7 no pending byte", exp_q.size(), 0);

      // Clear while idle (R4)
      @(negedge clk);
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      m_crc = 8'h00;
      chk("R4 clear idle", crc_o, 8'h00);
      chk("R5 zero after clear", zero_o, 1'b1);

      // Clear in mid-byte (R4)
      send_byte(8'h77, 1'b0);
      abort_run = 1'b1;
      @(negedge clk);
      byte_i = 8'h9E; byte_vld_i = 1'b1;
      @(negedge clk);
      byte_vld_i = 1'b0;
      repeat (3) @(negedge clk);
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      chk("R4 clear mid-byte crc", crc_o, 8'h00);
      chk("R4 clear mid-byte busy", busy_o, 1'b0);

      // Clear together with a byte strobe (R4)
      @(negedge clk);
      clr_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'hE1;
      @(negedge clk);
      clr_i = 1'b0; byte_vld_i = 1'b0;
      chk("R4 clear beats strobe busy", busy_o, 1'b0);
      repeat (9) @(negedge clk);
      chk("R4 clear beats strobe crc", crc_o, 8'h00);
      abort_run = 1'b0;
      m_crc = 8'h00;

      // Identity code with trailing check byte (R8)
      rom[0] = 8'h28; rom[1] = 8'h6D; rom[2] = 8'h13; rom[3] = 8'hB4;
      rom[4] = 8'h07; rom[5] = 8'h00; rom[6] = 8'h00;
      rom[7] = 8'h00;
      for (int i = 0; i < 7; i++) rom[7] = ref_byte(rom[7], rom[i]);
      for (int i = 0; i < 8; i++) send_byte(rom[i], 1'b0);
      chk("R8 code crc zero", crc_o, 8'h00);
      chk("R8 code zero flag", zero_o, 1'b1);

      repeat (3) @(negedge clk);
      done = 1'b1;
      report();
   end

endmodule